// File: doc/BRIEF.md
# Serial-Programmed Wiper Position Controller

This block is the digital control core of a single-channel variable resistor with 128 tap positions. A three-wire serial port (active-low select `cs_n`, serial clock `sclk`, data `sdi`) shifts bits into a 7-bit register. When the select line returns high, the register contents are copied into a 7-bit wiper latch. The latched code drives the tap decoder of the analog ladder, which is outside this block. The register's far stage is driven out on `sdo`, so several controllers can be chained without extra decoding.

The serial pins are asynchronous to the system clock `clk` and pass through a synchronizer. Each `sclk` phase must therefore last at least `SYNC_STAGES + 2` clock cycles. A low-power standby input drives two switch controls: one disconnects terminal A, the other ties the wiper to terminal B. The stored code is kept through standby, and the serial port keeps working while standby is active. A synchronous active-low reset places the wiper at midscale.

Top module: `digipot_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the wiper latch takes 0x40 (midscale), `sdo` goes to 0 and the shift register is cleared.
- R2: Bits are sampled on rising `sclk` edges while `cs_n` is low, most significant bit first. On the rising edge of `cs_n` the 7-bit register is copied to `wiper_code`.
- R3: A frame longer than seven bits leaves only its last seven bits in `wiper_code`. Earlier bits fall out of the register.
- R4: `sclk` edges while `cs_n` is high change neither the shift register nor `sdo`. `wiper_code` changes only on a rising edge of `cs_n`.
- R5: `sdo` changes only after a falling `sclk` edge while `cs_n` is low. It then shows bit 6 of the shift register, which is the bit that the next rising edge shifts out.
- R6: While `standby_n` is low, `term_a_open` and `wiper_to_b` are both 1. While it is high, both are 0.
- R7: `wiper_code` keeps its value through entry into and exit from standby.
- R8: Frames received during standby load `wiper_code` as usual. The new code is in effect when standby ends.
- R9: If reset is low when a rising edge of `cs_n` arrives, reset wins: the latch holds 0x40 after reset ends, and no load happens.
- R10: A frame shorter than seven bits shifts its bits in at the low end. The older register bits move up, and all seven bits are latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low; a rising edge latches the code |
| sclk | input | 1 | Serial clock; data sampled on rise, `sdo` updated on fall |
| sdi | input | 1 | Serial data in, MSB first |
| standby_n | input | 1 | Low-power standby, active low |
| sdo | output | 1 | Serial data out from the register's far stage |
| wiper_code | output | 7 | Latched tap position, 0 to 127 |
| term_a_open | output | 1 | 1 = disconnect terminal A |
| wiper_to_b | output | 1 | 1 = tie the wiper to terminal B |

## Verification
The bench tracks its own model of the shift register, the latched code and `sdo`, and compares all outputs after every serial edge.

It sends:
- a twelve-bit frame, which a design latching the first bits would fail;
- a three-bit frame, which a design clearing the register at select would fail;
- clock pulses with select high, which a design without select gating would shift into the register;
- a select rise during reset, which a design giving the load priority would turn into a non-midscale code.

It also checks that `sdo` holds between the rising and falling edges. A design that drives `sdo` from the rising edge would present the next bit half a cycle early and break a chain. The standby sequence covers two faults: a design that clears the code in standby, and one that stalls the port during standby.

// File: rtl/digipot_ctrl_pkg.sv
// Package: shared constants and the bundle type for the serial pins.
package digipot_ctrl_pkg;

    // Default wiper code width; 7 bits give 128 taps.
    localparam int unsigned DEF_CODE_W = 7;

    // Asynchronous pins, sampled together so their relative timing is kept.
    typedef struct packed {
        logic standby_n;
        logic cs_n;
        logic sclk;
        logic sdi;
    } pin_bundle_t;

    // Idle pin levels loaded into the synchronizer during reset.
    localparam pin_bundle_t PINS_IDLE = '{standby_n: 1'b1, cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0};

    // Midscale code for a given width: only the top bit set.
    function automatic logic [31:0] midscale(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction

endpackage

// File: rtl/digipot_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: every bit may change at any time; the output lags by STAGES clocks.
module digipot_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= din;
    end

    // Each later stage follows the one before it.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/digipot_edge.sv
// Module: single-edge detector on a synchronized level.
// Assumes: the input is already synchronous to clk; IDLE is the level after reset.
module digipot_edge #(
    parameter bit RISING = 1'b1,
    parameter bit IDLE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);

    logic prev;

    // Keep the previous level to compare against.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= level;
    end

    if (RISING) begin : g_rise
        assign pulse = level & ~prev;
    end else begin : g_fall
        assign pulse = ~level & prev;
    end

endmodule

// File: rtl/digipot_shifter.sv
// Module: serial-in shift register with a far-end serial output for chaining.
// Assumes: shift_en and out_en are single-cycle pulses and never fire together.
module digipot_shifter #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         out_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic         sdo
);

    // Move the register one place toward the top and take the new bit at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], din};
    end

    // Show the top stage on the serial output after a falling clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      sdo <= 1'b0;
        else if (out_en) sdo <= q[W-1];
    end

endmodule

// File: rtl/digipot_latch.sv
// Module: wiper code latch, preset to midscale by reset.
// Assumes: load is a single-cycle pulse; reset has priority over load.
module digipot_latch #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] MID = W'(digipot_ctrl_pkg::midscale(W));

    // Hold the tap code; reset wins over a simultaneous load.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= MID;
        else if (load) q <= d;
    end

endmodule

// File: rtl/digipot_switch.sv
// Module: registered analog switch controls for standby.
// Assumes: standby_n is synchronized; outputs lag it by one clock.
module digipot_switch (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_n,
    output logic a_open,
    output logic w_to_b
);

    // In standby, open terminal A and short the wiper to B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_open <= 1'b0;
            w_to_b <= 1'b0;
        end else begin
            a_open <= ~standby_n;
            w_to_b <= ~standby_n;
        end
    end

endmodule

// File: rtl/digipot_ctrl.sv
// Module: top of the wiper position controller.
// Assumes: each sclk phase lasts at least SYNC_STAGES + 2 clk cycles; SPI mode 0, MSB first.
module digipot_ctrl #(
    parameter int unsigned CODE_W      = digipot_ctrl_pkg::DEF_CODE_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              standby_n,
    output logic              sdo,
    output logic [CODE_W-1:0] wiper_code,
    output logic              term_a_open,
    output logic              wiper_to_b
);

    import digipot_ctrl_pkg::*;

    pin_bundle_t pins_raw, pins_s;
    logic        sclk_rise, sclk_fall, cs_rise;
    logic [CODE_W-1:0] shift_q;

    assign pins_raw = '{standby_n: standby_n, cs_n: cs_n, sclk: sclk, sdi: sdi};

    digipot_sync #(
        .W       ($bits(pin_bundle_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    digipot_edge #(.RISING(1'b1), .IDLE(1'b0)) u_sclk_rise (
        .clk(clk), .rst_n(rst_n), .level(pins_s.sclk), .pulse(sclk_rise)
    );

    digipot_edge #(.RISING(1'b0), .IDLE(1'b0)) u_sclk_fall (
        .clk(clk), .rst_n(rst_n), .level(pins_s.sclk), .pulse(sclk_fall)
    );

    digipot_edge #(.RISING(1'b1), .IDLE(1'b1)) u_cs_rise (
        .clk(clk), .rst_n(rst_n), .level(pins_s.cs_n), .pulse(cs_rise)
    );

    digipot_shifter #(.W(CODE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise & ~pins_s.cs_n),
        .out_en   (sclk_fall & ~pins_s.cs_n),
        .din      (pins_s.sdi),
        .q        (shift_q),
        .sdo      (sdo)
    );

    digipot_latch #(.W(CODE_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cs_rise),
        .d     (shift_q),
        .q     (wiper_code)
    );

    digipot_switch u_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_n (pins_s.standby_n),
        .a_open    (term_a_open),
        .w_to_b    (wiper_to_b)
    );

endmodule

// File: rtl/digipot_ctrl_checker.sv
// Module: property checker bound to the controller top.
// Assumes: sampling on clk; internal pulses come from the detector instances.
module digipot_ctrl_checker #(
    parameter int unsigned CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_s,
    input logic              cs_rise,
    input logic              sclk_fall,
    input logic [CODE_W-1:0] shift_q,
    input logic [CODE_W-1:0] wiper_code,
    input logic              sdo,
    input logic              term_a_open,
    input logic              wiper_to_b
);

    localparam logic [CODE_W-1:0] MID = CODE_W'(digipot_ctrl_pkg::midscale(CODE_W));

    logic rst_seen_low;

    // Remember whether reset was low at the previous edge.
    always_ff @(posedge clk) rst_seen_low <= !rst_n;

    // Checked away from the edge once the reset value has settled.
    always @(negedge clk) begin
        if (rst_seen_low === 1'b1) begin
            AST_RESET_MIDSCALE: assert (wiper_code == MID && sdo == 1'b0); // R1
        end
    end

    AST_LOAD_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (wiper_code == $past(shift_q))); // R2

    AST_HOLD_WITHOUT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(wiper_code)); // R4

    AST_SDO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo)); // R5

    AST_STANDBY_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_s |=> (term_a_open && wiper_to_b)); // R6

    AST_ACTIVE_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        standby_s |=> (!term_a_open && !wiper_to_b)); // R6

endmodule

bind digipot_ctrl digipot_ctrl_checker #(.CODE_W(CODE_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_s   (pins_s.standby_n),
    .cs_rise     (cs_rise),
    .sclk_fall   (sclk_fall),
    .shift_q     (shift_q),
    .wiper_code  (wiper_code),
    .sdo         (sdo),
    .term_a_open (term_a_open),
    .wiper_to_b  (wiper_to_b)
);

// File: tb/digipot_ctrl_test.sv
// Bench: scoreboard bench for the wiper position controller.
module digipot_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WATCHDOG   = 50000;

    typedef struct {
        logic [6:0] code;
        logic       a_open;
        logic       w_b;
        logic       sdo;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       standby_n = 1'b1;
    logic       sdo;
    logic [6:0] wiper_code;
    logic       term_a_open;
    logic       wiper_to_b;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // Bench model of the requirements
    logic [6:0] sr_m   = '0;
    logic [6:0] code_m = 7'h40;
    logic       sdo_m  = 1'b0;
    logic       shdn_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    digipot_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .standby_n   (standby_n),
        .sdo         (sdo),
        .wiper_code  (wiper_code),
        .term_a_open (term_a_open),
        .wiper_to_b  (wiper_to_b)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input string req);
        exp_t e;
        e.code = code_m; e.a_open = shdn_m; e.w_b = shdn_m; e.sdo = sdo_m; e.req = req;
        sb_q.push_back(e);
    endtask

    // One serial bit; checks sdo holds after the rise and updates after the fall.
    task automatic shift_bit(input logic b, input string req);
        sdi = b;
        wait_clk(HALF);
        sclk = 1'b1;
        sr_m = {sr_m[5:0], b};
        wait_clk(HALF);
        push({req, " R5 hold after rise"});
        sclk = 1'b0;
        sdo_m = sr_m[6];
        wait_clk(HALF);
        push({req, " R5 after fall"});
    endtask

    // Full frame of nbits, MSB first, then select high and check the latch.
    task automatic frame(input logic [15:0] val, input int nbits, input string req);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(val[i], req);
        cs_n = 1'b1;
        code_m = sr_m;
        wait_clk(2 * HALF);
        push({req, " latched"});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(6);
        rst_n = 1'b1;
        sr_m = '0; code_m = 7'h40; sdo_m = 1'b0;
        wait_clk(HALF);
    endtask

    // Monitor: pops expected items and compares outputs between edges.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (wiper_code !== e.code || term_a_open !== e.a_open ||
                wiper_to_b !== e.w_b || sdo !== e.sdo) begin
                errors++;
                $display("FAIL %s: code=%h a_open=%b w_b=%b sdo=%b expected code=%h a_open=%b w_b=%b sdo=%b",
                         e.req, wiper_code, term_a_open, wiper_to_b, sdo,
                         e.code, e.a_open, e.w_b, e.sdo);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_clk(2);
        do_reset();
        push("R1 reset state");

        frame(16'h25, 7, "R2 frame 0x25");
        frame(16'h5A, 7, "R2 frame 0x5A");

        // Twelve bits; only the last seven (0x4D) remain
        frame(16'hACD, 12, "R3 long frame");

        // Clock pulses with select high must not shift
        sdi = 1'b1;
        for (int i = 0; i < 7; i++) begin
            wait_clk(HALF); sclk = 1'b1;
            wait_clk(HALF); sclk = 1'b0;
        end
        wait_clk(HALF);
        push("R4 clocks with select high");

        // Short frame: 0x4D shifted by three, then 010 -> 0x6A
        frame(16'h2, 3, "R10 short frame");
        if (code_m !== 7'h6A) begin
            errors++;
            $display("FAIL R10 model: actual=%h expected=6a", code_m);
        end

        // Standby entry and exit keep the code
        standby_n = 1'b0; shdn_m = 1'b1;
        wait_clk(HALF);
        push("R6 standby switches");
        push("R7 code kept in standby");
        standby_n = 1'b1; shdn_m = 1'b0;
        wait_clk(HALF);
        push("R7 code after standby");

        // Load during standby
        standby_n = 1'b0; shdn_m = 1'b1;
        wait_clk(HALF);
        frame(16'h11, 7, "R8 frame in standby");
        standby_n = 1'b1; shdn_m = 1'b0;
        wait_clk(HALF);
        push("R8 new code after standby");

        // Select rises while reset is low: reset wins
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 6; i >= 0; i--) shift_bit(1'b1, "R9 prefill");
        rst_n = 1'b0;
        cs_n = 1'b1;
        wait_clk(6);
        rst_n = 1'b1;
        sr_m = '0; code_m = 7'h40; sdo_m = 1'b0;
        wait_clk(2 * HALF);
        push("R9 reset beats select");
        push("R1 reset state again");

        // Register was cleared by reset: 101 -> 0x05
        frame(16'h5, 3, "R1 R10 cleared register");
        frame(16'h7F, 7, "R2 all ones");
        frame(16'h00, 7, "R2 all zeros");

        wait (sb_q.size() == 0);
        wait_clk(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule